// File: doc/BRIEF.md
# Memory Row Boundary Decoder

This block takes a physical address and tells which of eight memory rows (chip selects) holds it. Software programs one 8-bit cumulative upper boundary per row, counted in 8 MB units, plus one byte whose bits mark each row as able or unable to carry check bits. Each row covers the span from the previous row's limit up to its own limit. Row 0 starts at address zero.

The decode is purely combinational on the lookup address. The outputs are a hit flag, the selected row index, and that row's check-bit capability. A row whose limit equals its base holds no memory and is never chosen. A boundary of zero that follows a nonzero limit stands for a 2 GB limit, so a fully populated large configuration can reach the top of a 31-bit space.

Top module: `drow_boundary_decoder`

## Requirements
- R1: After synchronous reset every boundary and every capability bit is zero, so every lookup gives hit 0, row 0 and ecc 0.
- R2: A write with `cfg_we` high and `cfg_addr` equal to N (0..7) loads boundary N from `cfg_wdata`. A write to `cfg_addr` 8 loads the capability byte, where bit N belongs to row N. Each write changes the decode from the cycle after the clock edge that takes it.
- R3: Writes with `cfg_addr` 9 to 15 have no effect on any boundary, on the capability byte, or on the decode.
- R4: A row's limit is its boundary value times 8 MB (value shifted left by 23). Row N covers addresses from the limit of row N-1 (zero for row 0) up to, but not including, its own limit.
- R5: A boundary of zero whose preceding limit is nonzero gives a limit of 0x8000_0000 (2 GB).
- R6: A row whose limit equals its base is empty and is never selected.
- R7: An address that no row covers, including any address at or above the highest limit, gives hit 0, row 0 and ecc 0.
- R8: On a hit, `row_ecc` equals the capability bit of the selected row. A 0 bit marks a row without check bits.
- R9: When boundaries decrease and several rows cover an address, the lowest-index row is selected.
- R10: The outputs follow `lookup_addr` combinationally, with no clock edge between an address change and the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select: 0..7 boundaries, 8 capability byte |
| cfg_wdata | input | 8 | Configuration write data |
| lookup_addr | input | 32 | Physical address to decode |
| row_hit | output | 1 | Address falls inside a populated row |
| row_idx | output | 3 | Selected row, 0 when there is no hit |
| row_ecc | output | 1 | Selected row carries check bits |

## Verification
A corrupted boundary register or a broken limit chain shifts the edge of one row. The bench only sees that at addresses next to the edge, so it probes one below and exactly at every limit, including the 2 GB wrap. A bad capability byte appears only when the affected row is selected. Every stored fault becomes visible in the cycle right after the write that exposes it, because the decode is combinational. A per-cycle model comparison and a long random sweep catch faults that sit away from the directed probes.

// File: rtl/drow_pkg.sv
package drow_pkg;

    localparam int NUM_ROWS_D   = 8;
    localparam int BND_W_D      = 8;
    localparam int ADDR_W_D     = 32;
    localparam int UNIT_SHIFT_D = 23;
    localparam int CFG_AW_D     = 4;

    // which configuration register a write targets
    typedef enum logic [1:0] {
        CFG_SEL_BOUND = 2'd0,
        CFG_SEL_MASK  = 2'd1,
        CFG_SEL_NONE  = 2'd2
    } cfg_sel_e;

    function automatic cfg_sel_e classify_cfg(input int unsigned addr, input int unsigned rows);
        if (addr < rows)       return CFG_SEL_BOUND;
        else if (addr == rows) return CFG_SEL_MASK;
        else                   return CFG_SEL_NONE;
    endfunction

endpackage

// File: rtl/drow_cfg_regs.sv
module drow_cfg_regs
    import drow_pkg::*;
#(
    parameter int NUM_ROWS = NUM_ROWS_D,
    parameter int BND_W    = BND_W_D,
    parameter int CFG_AW   = CFG_AW_D
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [CFG_AW-1:0]                  cfg_addr,
    input  logic [BND_W-1:0]                   cfg_wdata,
    output logic [NUM_ROWS-1:0][BND_W-1:0]     bnd_q,
    output logic [NUM_ROWS-1:0]                ecc_mask_q
);
    localparam int MASK_FROM_DATA = (NUM_ROWS < BND_W) ? NUM_ROWS : BND_W;

    cfg_sel_e                 sel;
    logic [NUM_ROWS-1:0]      mask_next;

    always_comb begin
        sel = classify_cfg(int'(cfg_addr), NUM_ROWS);
    end

    generate
        for (genvar m = 0; m < NUM_ROWS; m++) begin : g_mask_bit
            if (m < MASK_FROM_DATA) begin : g_from_data
                assign mask_next[m] = cfg_wdata[m];
            end else begin : g_zero
                assign mask_next[m] = 1'b0;
            end
        end

        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_bound
            always_ff @(posedge clk) begin
                if (rst) begin
                    bnd_q[r] <= '0;
                end else if (cfg_we && sel == CFG_SEL_BOUND && int'(cfg_addr) == r) begin
                    bnd_q[r] <= cfg_wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ecc_mask_q <= '0;
        end else if (cfg_we && sel == CFG_SEL_MASK) begin
            ecc_mask_q <= mask_next;
        end
    end

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && int'(cfg_addr) > NUM_ROWS) |=> ($stable(bnd_q) && $stable(ecc_mask_q))) // R3
        else $error("write to unused select changed state");

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (bnd_q == '0 && ecc_mask_q == '0)) // R1
        else $error("reset left configuration nonzero");

endmodule

// File: rtl/drow_limit_chain.sv
module drow_limit_chain
    import drow_pkg::*;
#(
    parameter int NUM_ROWS   = NUM_ROWS_D,
    parameter int BND_W      = BND_W_D,
    parameter int ADDR_W     = ADDR_W_D,
    parameter int UNIT_SHIFT = UNIT_SHIFT_D
) (
    input  logic [NUM_ROWS-1:0][BND_W-1:0]  bnd,
    output logic [NUM_ROWS-1:0][ADDR_W-1:0] row_base,
    output logic [NUM_ROWS-1:0][ADDR_W-1:0] row_limit
);
    // a zero boundary after a nonzero one means one step past the encodable range
    localparam int WRAP_BIT = BND_W + UNIT_SHIFT;
    localparam logic [ADDR_W-1:0] WRAP_LIMIT = ADDR_W'(1) << WRAP_BIT;

    generate
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            logic [ADDR_W-1:0] prev_lim;
            logic [ADDR_W-1:0] scaled;

            if (r == 0) begin : g_first
                assign prev_lim = '0;
            end else begin : g_next
                assign prev_lim = row_limit[r-1];
            end

            assign scaled = ADDR_W'(bnd[r]) << UNIT_SHIFT;

            always_comb begin
                row_base[r] = prev_lim;
                if (prev_lim != '0 && bnd[r] == '0) begin
                    row_limit[r] = WRAP_LIMIT;
                end else begin
                    row_limit[r] = scaled;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/drow_range_match.sv
module drow_range_match
    import drow_pkg::*;
#(
    parameter int NUM_ROWS = NUM_ROWS_D,
    parameter int ADDR_W   = ADDR_W_D
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_ROWS-1:0][ADDR_W-1:0] row_base,
    input  logic [NUM_ROWS-1:0][ADDR_W-1:0] row_limit,
    output logic [NUM_ROWS-1:0]             in_range
);
    generate
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cmp
            // a span with limit <= base can never contain an address
            assign in_range[r] = (addr >= row_base[r]) && (addr < row_limit[r]);
        end
    endgenerate

endmodule

// File: rtl/drow_priority_pick.sv
module drow_priority_pick
    import drow_pkg::*;
#(
    parameter int NUM_ROWS = NUM_ROWS_D,
    localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic [NUM_ROWS-1:0] in_range,
    input  logic [NUM_ROWS-1:0] ecc_mask,
    output logic                hit,
    output logic [ROW_W-1:0]    row,
    output logic                ecc
);
    always_comb begin
        hit = 1'b0;
        row = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (in_range[i]) begin
                hit = 1'b1;
                row = ROW_W'(i);
            end
        end
        ecc = hit & ecc_mask[row];
    end

endmodule

// File: rtl/drow_boundary_decoder.sv
module drow_boundary_decoder
    import drow_pkg::*;
#(
    parameter int NUM_ROWS   = NUM_ROWS_D,
    parameter int BND_W      = BND_W_D,
    parameter int ADDR_W     = ADDR_W_D,
    parameter int UNIT_SHIFT = UNIT_SHIFT_D,
    parameter int CFG_AW     = CFG_AW_D,
    localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BND_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              row_hit,
    output logic [ROW_W-1:0]  row_idx,
    output logic              row_ecc
);
    logic [NUM_ROWS-1:0][BND_W-1:0]  bnd_q;
    logic [NUM_ROWS-1:0]             ecc_mask_q;
    logic [NUM_ROWS-1:0][ADDR_W-1:0] base_w;
    logic [NUM_ROWS-1:0][ADDR_W-1:0] limit_w;
    logic [NUM_ROWS-1:0]             in_range_w;

    drow_cfg_regs #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W),
        .CFG_AW   (CFG_AW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .bnd_q      (bnd_q),
        .ecc_mask_q (ecc_mask_q)
    );

    drow_limit_chain #(
        .NUM_ROWS   (NUM_ROWS),
        .BND_W      (BND_W),
        .ADDR_W     (ADDR_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_chain (
        .bnd       (bnd_q),
        .row_base  (base_w),
        .row_limit (limit_w)
    );

    drow_range_match #(
        .NUM_ROWS (NUM_ROWS),
        .ADDR_W   (ADDR_W)
    ) u_match (
        .addr      (lookup_addr),
        .row_base  (base_w),
        .row_limit (limit_w),
        .in_range  (in_range_w)
    );

    drow_priority_pick #(
        .NUM_ROWS (NUM_ROWS)
    ) u_pick (
        .in_range (in_range_w),
        .ecc_mask (ecc_mask_q),
        .hit      (row_hit),
        .row      (row_idx),
        .ecc      (row_ecc)
    );

    AST_HIT_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        row_hit |-> (lookup_addr >= base_w[row_idx] && lookup_addr < limit_w[row_idx])) // R4
        else $error("selected row does not contain address");

    AST_EMPTY_NOT_PICKED: assert property (@(posedge clk) disable iff (rst)
        row_hit |-> (limit_w[row_idx] != base_w[row_idx])) // R6
        else $error("empty row selected");

    AST_MISS_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        !row_hit |-> (row_idx == '0 && !row_ecc)) // R7
        else $error("miss without zero row and ecc");

    AST_ECC_OF_ROW: assert property (@(posedge clk) disable iff (rst)
        row_hit |-> (row_ecc == ecc_mask_q[row_idx])) // R8
        else $error("ecc flag mismatches selected row");

    AST_NO_LOWER_MATCH: assert property (@(posedge clk) disable iff (rst)
        row_hit |-> ((in_range_w & ((NUM_ROWS'(1) << row_idx) - NUM_ROWS'(1))) == '0)) // R9
        else $error("lower row also covers address");

endmodule

// File: tb/drow_boundary_decoder_bench.sv
module drow_boundary_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [31:0] lookup_addr = '0;
    logic        row_hit;
    logic [2:0]  row_idx;
    logic        row_ecc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live_cmp = 1'b0;

    // behavioural reference state
    int unsigned m_bnd [8];
    int unsigned m_mask;

    always #(CLK_PERIOD / 2) clk = ~clk;

    drow_boundary_decoder u_drow_boundary_decoder (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .lookup_addr (lookup_addr),
        .row_hit     (row_hit),
        .row_idx     (row_idx),
        .row_ecc     (row_ecc)
    );

    // R2: register writes take effect at the clock edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_bnd[i] <= 0;
            m_mask <= 0;
        end else if (cfg_we) begin
            if (cfg_addr < 8) m_bnd[cfg_addr] <= cfg_wdata;
            else if (cfg_addr == 8) m_mask <= cfg_wdata;
        end
    end

    function automatic void model(input logic [31:0] a, output bit h, output int r, output bit e);
        longint last = 0;
        longint lim;
        longint aa = longint'(a);
        h = 0; r = 0;
        for (int i = 0; i < 8; i++) begin
            lim = longint'(m_bnd[i]) * 64'd8388608;
            if (last != 0 && m_bnd[i] == 0) lim = 64'h8000_0000;
            if (!h && aa >= last && aa < lim) begin h = 1; r = i; end
            last = lim;
        end
        e = h ? m_mask[r] : 1'b0;
    endfunction

    task automatic cmp_model(input string tag);
        bit h; int r; bit e;
        model(lookup_addr, h, r, e);
        checks++;
        if (row_hit !== h || int'(row_idx) !== r || row_ecc !== e) begin
            errors++;
            $display("FAIL %s addr=%h actual hit=%0b row=%0d ecc=%0b expected hit=%0b row=%0d ecc=%0b",
                     tag, lookup_addr, row_hit, row_idx, row_ecc, h, r, e);
        end
    endtask

    // per-cycle comparison against the model, after the edge settles
    always @(posedge clk) begin
        #1;
        if (live_cmp && !rst && !done) cmp_model("R2 R4 R8 per-cycle");
    end

    task automatic expect_out(input string tag, input logic [31:0] a,
                              input bit h, input int r, input bit e);
        @(negedge clk);
        lookup_addr = a;
        #1;
        checks++;
        if (row_hit !== h || int'(row_idx) !== r || row_ecc !== e) begin
            errors++;
            $display("FAIL %s addr=%h actual hit=%0b row=%0d ecc=%0b expected hit=%0b row=%0d ecc=%0b",
                     tag, a, row_hit, row_idx, row_ecc, h, r, e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_bounds(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
        wr(4'd0, b0); wr(4'd1, b1); wr(4'd2, b2); wr(4'd3, b3);
        wr(4'd4, b4); wr(4'd5, b5); wr(4'd6, b6); wr(4'd7, b7);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live_cmp = 1'b1;

        // R1 reset state
        expect_out("R1 reset addr 0", 32'h0, 0, 0, 0);
        expect_out("R1 reset high addr", 32'h7000_0000, 0, 0, 0);

        // R2 R4 R6 R8 cumulative layout with empty rows 2 and 5
        load_bounds(8'h02, 8'h04, 8'h04, 8'h08, 8'h10, 8'h10, 8'h20, 8'h40);
        wr(4'd8, 8'b1010_1101);
        expect_out("R4 row0 base", 32'h0000_0000, 1, 0, 1);
        expect_out("R4 row0 top", 32'h00FF_FFFF, 1, 0, 1);
        expect_out("R4 row1 base", 32'h0100_0000, 1, 1, 0);
        expect_out("R6 skip empty row2", 32'h0200_0000, 1, 3, 1);
        expect_out("R8 row4 ecc", 32'h0400_0000, 1, 4, 0);
        expect_out("R6 skip empty row5", 32'h0800_0000, 1, 6, 0);
        expect_out("R8 row7 ecc", 32'h1FFF_FFFF, 1, 7, 1);
        expect_out("R7 at top limit", 32'h2000_0000, 0, 0, 0);
        expect_out("R7 far above", 32'hFFFF_FFFF, 0, 0, 0);

        // R10 combinational follow without a clock edge
        @(negedge clk);
        lookup_addr = 32'h0180_0000; #1;
        checks++;
        if (row_idx !== 3'd1 || row_hit !== 1'b1) begin
            errors++; $display("FAIL R10 actual row=%0d expected 1", row_idx);
        end
        lookup_addr = 32'h1000_0000; #1;
        checks++;
        if (row_idx !== 3'd7 || row_hit !== 1'b1) begin
            errors++; $display("FAIL R10 actual row=%0d expected 7", row_idx);
        end

        // R3 unused selects ignored
        for (int a = 9; a < 16; a++) wr(4'(a), 8'hFF);
        expect_out("R3 after unused writes row0", 32'h00FF_FFFF, 1, 0, 1);
        expect_out("R3 after unused writes row1", 32'h0100_0000, 1, 1, 0);
        expect_out("R3 after unused writes top", 32'h2000_0000, 0, 0, 0);

        // R5 zero after nonzero means 2 GB
        wr(4'd7, 8'h00);
        expect_out("R5 wrap row7 low", 32'h1000_0000, 1, 7, 1);
        expect_out("R5 wrap row7 top", 32'h7FFF_FFFF, 1, 7, 1);
        expect_out("R5 beyond 2GB", 32'h8000_0000, 0, 0, 0);
        // R5 R6 zero after 2 GB: row6 wraps, row7 empty
        wr(4'd6, 8'h00);
        expect_out("R5 row6 wraps", 32'h7FFF_FFFF, 1, 6, 0);
        expect_out("R6 row7 empty after wrap", 32'h8000_0000, 0, 0, 0);

        // R6 leading zero row0 empty, row1 begins at 0
        load_bounds(8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04);
        expect_out("R6 row0 empty", 32'h0000_0000, 1, 1, 0);
        expect_out("R7 above row1", 32'h0200_0000, 0, 0, 0);

        // R9 overlapping spans from a decreasing boundary
        load_bounds(8'h10, 8'h08, 8'h20, 8'h20, 8'h20, 8'h20, 8'h20, 8'h20);
        wr(4'd8, 8'b0000_0100);
        expect_out("R9 lowest wins", 32'h0500_0000, 1, 0, 0);
        expect_out("R9 only row2", 32'h0900_0000, 1, 2, 1);
        expect_out("R9 below row2", 32'h0300_0000, 1, 0, 0);

        // random sweep against the model, compared every cycle
        for (int n = 0; n < 60; n++) begin
            wr(4'($urandom_range(0, 8)), ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom));
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                lookup_addr = ($urandom_range(0, 1) == 0) ? $urandom : (32'($urandom_range(0, 255)) << 23);
            end
        end

        // R1 reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_out("R1 second reset", 32'h0000_0000, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule